// File: doc/BRIEF.md
# Debounced Demo State Selector

The block picks which of seven operating states a demonstration system runs in. State 0 is a one-shot initialization phase. States 1 through 6 are the operating states, running from a ready state up to a hibernate state. The selector starts in state 0 after reset. It spends a fixed number of cycles there and then moves to state 1. After that it never returns to state 0.

Once initialization is over, user inputs move the state, and a configuration input chooses how. In button mode, an increment button steps the state up by one and a decrement button steps it down by one. In rotary mode, a 4-bit switch code is loaded only when a commit button is pressed. Codes that name no operating state land on the hibernate state.

All raw inputs are asynchronous. They pass through synchronizer chains, and each button press is reduced to a single edge. The block reports the current state number, a one-cycle pulse whenever that number changes, and the input mode it is using.

Top module: `demo_state_selector`

## Requirements
- R1: While reset is held, `state_o` is 0 and `state_chg_o` is 0. After reset is released, `state_o` stays 0 for `INIT_CYCLES`-1 rising edges. On edge number `INIT_CYCLES` it becomes 1, with `state_chg_o` high. Button edges seen during initialization are discarded.
- R2: Once `state_o` has left 0, no input sequence returns it to 0.
- R3: In button mode (`cfg_rotary_i` = 0), an increment press adds one to the state. From state 6 it leaves the state at 6.
- R4: In button mode, a decrement press subtracts one from the state. From state 1 it leaves the state at 1.
- R5: In rotary mode (`cfg_rotary_i` = 1), only a commit press changes the state, and increment and decrement presses have no effect. In button mode, a commit press has no effect.
- R6: On commit, rotary codes 1 to 6 select that state. Code 0 and codes 7 to 15 select state 6.
- R7: A press changes the state exactly once, however long the button is held. The new state appears on the third rising edge after the raw input first goes high.
- R8: `state_chg_o` is high for exactly one cycle, and only in the cycle in which `state_o` takes a value different from the one it had before. A press that leaves the state unchanged gives no pulse.
- R9: If increment and decrement edges arrive in the same cycle, increment wins.
- R10: `mode_rotary_o` shows `cfg_rotary_i` one rising edge later. The registered value is the one that selects the active input mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_inc_i | input | 1 | Raw increment button, asynchronous |
| btn_dec_i | input | 1 | Raw decrement button, asynchronous |
| btn_commit_i | input | 1 | Raw commit button for rotary mode, asynchronous |
| rot_code_i | input | ROT_W | Raw rotary switch code |
| cfg_rotary_i | input | 1 | Mode select: 0 = buttons, 1 = rotary plus commit |
| state_o | output | 3 | Current state number, 0 to 6 |
| state_chg_o | output | 1 | One-cycle pulse when `state_o` changes |
| mode_rotary_o | output | 1 | Registered mode select in use |

## Verification
A wrong state register shows at `state_o` as soon as the next edge registers it. The bench compares that value with its own model after every press, so an error is caught within one press. A broken edge detector gives repeated steps while a button is held, and a wrong synchronizer depth moves the change by a cycle. The bench samples one cycle before and one cycle after the expected edge, so both faults show up on the very press that causes them. A wrong change-pulse rule shows either as a pulse on a press that saturates or as a pulse that stays high on the following cycle.

// File: rtl/dss_pkg.sv
package dss_pkg;
   localparam int unsigned STATE_W = 3;
   typedef logic [STATE_W-1:0] dss_state_t;

   localparam dss_state_t ST_INIT  = 3'd0;
   localparam dss_state_t ST_READY = 3'd1;
   localparam dss_state_t ST_HIB   = 3'd6;

   localparam int unsigned EVT_W = 3;
   typedef struct packed {
      logic commit;
      logic inc;
      logic dec;
   } dss_evt_t;
endpackage

// File: rtl/dss_sync.sv
module dss_sync #(
   parameter int unsigned W           = 1,
   parameter int unsigned STAGES      = 2,
   parameter bit          EDGE_DETECT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dss_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dss_sync: W must be at least 1");
   end

   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
      end
   end

   if (EDGE_DETECT) begin : g_edge
      logic [W-1:0] prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= '0;
         else        prev_q <= stg_q[STAGES-1];
      end
      assign q_o = stg_q[STAGES-1] & ~prev_q;

      for (genvar b = 0; b < W; b++) begin : g_chk
         AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            q_o[b] |=> !q_o[b]); // R7
      end
   end else begin : g_level
      assign q_o = stg_q[STAGES-1];
   end
endmodule

// File: rtl/dss_target.sv
module dss_target
   import dss_pkg::*;
#(
   parameter int unsigned ROT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  dss_state_t       cur_i,
   input  dss_evt_t         evt_i,
   input  logic [ROT_W-1:0] rot_i,
   input  logic             rotary_mode_i,
   output dss_state_t       nxt_o
);
   if (ROT_W < STATE_W) begin : g_bad_rot
      $error("dss_target: ROT_W must cover the state width");
   end

   function automatic dss_state_t fold_code(input logic [ROT_W-1:0] code);
      if (code == '0 || code > ROT_W'(ST_HIB)) return ST_HIB;
      else                                     return code[STATE_W-1:0];
   endfunction

   dss_state_t up_s, down_s;

   always_comb begin
      up_s   = (cur_i >= ST_HIB)   ? ST_HIB   : cur_i + 3'd1;
      down_s = (cur_i <= ST_READY) ? ST_READY : cur_i - 3'd1;
   end

   always_comb begin
      nxt_o = cur_i;
      if (cur_i != ST_INIT) begin
         if (rotary_mode_i) begin
            if (evt_i.commit) nxt_o = fold_code(rot_i);
         end else begin
            if (evt_i.inc)      nxt_o = up_s;
            else if (evt_i.dec) nxt_o = down_s;
         end
      end
   end

   AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (rotary_mode_i && evt_i.commit && cur_i != ST_INIT)
         |-> (nxt_o >= ST_READY && nxt_o <= ST_HIB)); // R6
   AST_BTN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!rotary_mode_i && cur_i != ST_INIT)
         |-> (nxt_o == cur_i || nxt_o == cur_i + 3'd1 || nxt_o == cur_i - 3'd1)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_i == '0) |-> (nxt_o == cur_i)); // R5
endmodule

// File: rtl/dss_core.sv
module dss_core
   import dss_pkg::*;
#(
   parameter int unsigned INIT_CYCLES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  dss_state_t nxt_i,
   input  logic       cfg_rotary_i,
   output dss_state_t state_o,
   output logic       chg_o,
   output logic       mode_o
);
   if (INIT_CYCLES < 1) begin : g_bad_init
      $error("dss_core: INIT_CYCLES must be at least 1");
   end

   localparam int unsigned CNT_W = (INIT_CYCLES > 1) ? $clog2(INIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYCLES - 1);

   dss_state_t       state_q;
   logic             chg_q;
   logic             mode_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_INIT;
         chg_q   <= 1'b0;
         cnt_q   <= '0;
      end else if (state_q == ST_INIT) begin
         if (cnt_q == CNT_LAST) begin
            state_q <= ST_READY;
            chg_q   <= 1'b1;
         end else begin
            cnt_q   <= cnt_q + 1'b1;
            chg_q   <= 1'b0;
         end
      end else begin
         state_q <= nxt_i;
         chg_q   <= (nxt_i != state_q);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_q <= 1'b0;
      else        mode_q <= cfg_rotary_i;
   end

   assign state_o = state_q;
   assign chg_o   = chg_q;
   assign mode_o  = mode_q;

   AST_INIT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_INIT) |=> (state_q == ST_INIT || state_q == ST_READY)); // R1
   AST_NO_REENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_INIT) |=> (state_q != ST_INIT)); // R2
   AST_CHG_REAL: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> (state_q != $past(state_q))); // R8
   AST_CHG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_q |-> $stable(state_q)); // R8
   AST_STATE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      state_q <= ST_HIB); // R6
endmodule

// File: rtl/demo_state_selector.sv
module demo_state_selector
   import dss_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INIT_CYCLES = 4,
   parameter int unsigned ROT_W       = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             btn_inc_i,
   input  logic             btn_dec_i,
   input  logic             btn_commit_i,
   input  logic [ROT_W-1:0] rot_code_i,
   input  logic             cfg_rotary_i,
   output logic [2:0]       state_o,
   output logic             state_chg_o,
   output logic             mode_rotary_o
);
   dss_evt_t         evt_s;
   logic [EVT_W-1:0] evt_raw, evt_edge;
   logic [ROT_W-1:0] rot_s;
   dss_state_t       cur_s, nxt_s;
   logic             mode_s;

   assign evt_raw = {btn_commit_i, btn_inc_i, btn_dec_i};
   assign evt_s   = dss_evt_t'(evt_edge);

   dss_sync #(.W(EVT_W), .STAGES(SYNC_STAGES), .EDGE_DETECT(1'b1)) u_btn_sync (
      .clk(clk), .rst_n(rst_n), .d_i(evt_raw), .q_o(evt_edge));

   dss_sync #(.W(ROT_W), .STAGES(SYNC_STAGES), .EDGE_DETECT(1'b0)) u_rot_sync (
      .clk(clk), .rst_n(rst_n), .d_i(rot_code_i), .q_o(rot_s));

   dss_target #(.ROT_W(ROT_W)) u_target (
      .clk(clk), .rst_n(rst_n), .cur_i(cur_s), .evt_i(evt_s), .rot_i(rot_s),
      .rotary_mode_i(mode_s), .nxt_o(nxt_s));

   dss_core #(.INIT_CYCLES(INIT_CYCLES)) u_core (
      .clk(clk), .rst_n(rst_n), .nxt_i(nxt_s), .cfg_rotary_i(cfg_rotary_i),
      .state_o(cur_s), .chg_o(state_chg_o), .mode_o(mode_s));

   assign state_o       = cur_s;
   assign mode_rotary_o = mode_s;
endmodule

// File: tb/tb_demo_state_selector.sv
module tb_demo_state_selector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       btn_inc = 1'b0, btn_dec = 1'b0, btn_commit = 1'b0;
   logic [3:0] rot = 4'd0;
   logic       cfg_rot = 1'b0;
   logic [2:0] state;
   logic       chg, mode;

   int checks = 0;
   int fails  = 0;
   int model  = 0;

   always #2 clk = ~clk;

   demo_state_selector dut (
      .clk(clk), .rst_n(rst_n), .btn_inc_i(btn_inc), .btn_dec_i(btn_dec),
      .btn_commit_i(btn_commit), .rot_code_i(rot), .cfg_rotary_i(cfg_rot),
      .state_o(state), .state_chg_o(chg), .mode_rotary_o(mode));

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int fold(input int c);
      return (c >= 1 && c <= 6) ? c : 6;
   endfunction

   task automatic press(input logic i, input logic d, input logic c,
                        input int exp, input string req);
      int prev;
      prev = model;
      @(negedge clk);
      btn_inc = i; btn_dec = d; btn_commit = c;
      repeat (2) @(posedge clk);
      @(negedge clk);
      check({req, " R7 latency hold"}, state, prev);
      @(negedge clk);
      check({req, " state"}, state, exp);
      check({req, " R8 pulse"}, chg, (exp != prev) ? 1 : 0);
      @(negedge clk);
      check({req, " R8 pulse width"}, chg, 0);
      repeat (4) @(negedge clk);
      check({req, " R7 no repeat"}, state, exp);
      btn_inc = 1'b0; btn_dec = 1'b0; btn_commit = 1'b0;
      repeat (4) @(negedge clk);
      model = exp;
   endtask

   task automatic t_reset_init();
      repeat (3) @(negedge clk);
      check("R1 reset state", state, 0);
      check("R1 reset pulse", chg, 0);
      @(negedge clk);
      rst_n = 1'b1;
      btn_inc = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 still init", state, 0);
      @(negedge clk);
      check("R1 ready", state, 1);
      check("R1 ready pulse", chg, 1);
      @(negedge clk);
      check("R8 init pulse width", chg, 0);
      repeat (4) @(negedge clk);
      check("R1 init edge discarded", state, 1);
      btn_inc = 1'b0;
      repeat (4) @(negedge clk);
      model = 1;
   endtask

   task automatic t_buttons();
      press(0, 1, 0, 1, "R4 sat at 1");
      for (int k = 2; k <= 6; k++) press(1, 0, 0, k, "R3 inc");
      press(1, 0, 0, 6, "R3 sat at 6");
      press(0, 1, 0, 5, "R4 dec");
      press(1, 1, 0, 6, "R9 inc wins");
      press(0, 1, 0, 5, "R4 dec again");
      @(negedge clk); rot = 4'd2;
      press(0, 0, 1, 5, "R5 commit ignored in button mode");
   endtask

   task automatic t_rotary();
      @(negedge clk);
      cfg_rot = 1'b1;
      @(negedge clk);
      check("R10 mode", mode, 1);
      press(1, 0, 0, model, "R5 inc ignored in rotary mode");
      press(0, 1, 0, model, "R5 dec ignored in rotary mode");
      for (int c = 0; c < 16; c++) begin
         @(negedge clk); rot = 4'(c);
         repeat (4) @(negedge clk);
         press(0, 0, 1, fold(c), "R6 fold");
         check("R2 never init", (state == 3'd0) ? 1 : 0, 0);
      end
      @(negedge clk); rot = 4'd3;
      repeat (4) @(negedge clk);
      press(0, 0, 1, 3, "R5 commit");
      press(0, 0, 1, 3, "R8 same state no pulse");
      @(negedge clk);
      cfg_rot = 1'b0;
      @(negedge clk);
      check("R10 mode back", mode, 0);
      press(1, 0, 0, 4, "R3 inc after mode switch");
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      t_reset_init();
      t_buttons();
      t_rotary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule